// File: doc/BRIEF.md
# Wrapping Burst Address Sequencer

This block produces the word address stream for a burst read out of a memory array. A start strobe loads a starting word address. After that, every advance pulse moves the address one step under the burst mode that was configured when the burst began. The mode can be open-ended continuous, or a linear burst of 8, 16 or 32 words. A linear burst either wraps inside its naturally aligned group of words or runs straight on. The array size is a power of two, and any address computation that passes the top of the array rolls over to word zero.

A 4-bit configuration word controls the sequencer. Bits [2:0] give the burst mode and bit [3] enables wrapping. The settings take effect at the next start strobe. If the mode field is written with an undefined code, the block falls back to continuous mode and raises a sticky error flag. The outputs are the current address, a busy flag, a done flag and the number of words issued so far in the burst.

Top module: `burst_addr_seq`

## Requirements
- R1: After a synchronous reset: `addr`=0, `count`=0, `busy`=0, `done`=0, `cfg_mode`=3'b000 (continuous), `cfg_wrap`=1 and `cfg_err`=0.
- R2: When `cfg_we` is high, `cfg_wdata[2:0]` is stored as the mode and `cfg_wdata[3]` as the wrap enable. Both are visible on `cfg_mode` and `cfg_wrap` in the next cycle. The defined mode codes are 3'b000 continuous, 3'b010 eight words, 3'b011 sixteen words and 3'b100 thirty-two words.
- R3: A write of mode code 3'b001, 3'b101, 3'b110 or 3'b111 stores 3'b000 and sets `cfg_err`. `cfg_err` stays set through later legal writes until reset.
- R4: In the cycle after `start`: `addr`=`start_addr`, `count`=1, `busy`=1 and `done`=0. `start` overrides `advance` and `stop` in the same cycle, and it restarts a burst that is already running. The burst uses the mode and wrap settings held in the configuration before that clock edge, so a `cfg_we` in the same cycle as `start` does not affect that burst.
- R5: In continuous mode, each `advance` adds one to `addr`. The all-ones address is followed by 0, and advances alone never raise `done`.
- R6: In an N-word linear burst with wrap enabled, each `advance` increments the low log2(N) address bits modulo N and leaves the upper bits unchanged.
- R7: In a linear burst with wrap disabled, each `advance` adds one to the full address. This crosses group boundaries and rolls over from the top of the array to 0.
- R8: In an N-word linear burst, `done` rises and `busy` falls in the same cycle that the Nth address appears with `count`=N. `done` and `busy` are never high together.
- R9: While `busy`, `stop` ends the burst in the next cycle: `done`=1 and `busy`=0. If `advance` is high in the same cycle, the address and count still step once.
- R10: When `busy` is low, `advance` and `stop` are ignored and `addr`, `count` and `done` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | [3] wrap enable, [2:0] burst mode code |
| cfg_mode | output | 3 | Stored burst mode |
| cfg_wrap | output | 1 | Stored wrap enable |
| cfg_err | output | 1 | Sticky flag: an undefined mode code was written |
| start | input | 1 | Load `start_addr` and begin a burst |
| start_addr | input | ADDR_W | Starting word address |
| advance | input | 1 | Step to the next address |
| stop | input | 1 | End the current burst |
| addr | output | ADDR_W | Current word address |
| count | output | COUNT_W | Words issued in the current burst |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Burst finished |

## Verification
A configuration write and a start strobe can arrive in the same cycle. The bench arranges this by setting an 8-word wrapping mode first. It then drives a continuous-mode write together with a start at an address whose low three bits are all ones. The first advance shows which mode was applied: a wrap back to the group base means the previous settings were used, while a step into the next group would be a failure. The bench also drives advance and stop in the same cycle of a continuous burst and expects one step with done raised.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam logic [2:0] MODE_CONT = 3'b000;
  localparam logic [2:0] MODE_G8   = 3'b010;
  localparam logic [2:0] MODE_G16  = 3'b011;
  localparam logic [2:0] MODE_G32  = 3'b100;

  function automatic logic mode_is_defined(input logic [2:0] code);
    return (code == MODE_CONT) || (code == MODE_G8) ||
           (code == MODE_G16)  || (code == MODE_G32);
  endfunction

  // log2 of the group size; 0 for continuous
  function automatic logic [2:0] group_log2(input logic [2:0] code);
    case (code)
      MODE_G8:  return 3'd3;
      MODE_G16: return 3'd4;
      MODE_G32: return 3'd5;
      default:  return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
  import burst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [3:0] wdata,
  output logic [2:0] mode_q,
  output logic       wrap_q,
  output logic       err_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_CONT;
      wrap_q <= 1'b1;
      err_q  <= 1'b0;
    end else if (we) begin
      wrap_q <= wdata[3];
      if (mode_is_defined(wdata[2:0])) begin
        mode_q <= wdata[2:0];
      end else begin
        mode_q <= MODE_CONT;
        err_q  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [2:0]        mode,
  input  logic              wrap_en,
  output logic [ADDR_W-1:0] nxt
);

  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] low_mask;

  always_comb begin
    inc      = cur + 1'b1;
    low_mask = ~({ADDR_W{1'b1}} << group_log2(mode));
    if (wrap_en && (mode != MODE_CONT))
      nxt = (cur & ~low_mask) | (inc & low_mask);
    else
      nxt = inc;
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ARRAY_WORDS = 1 << 24,
  parameter int COUNT_W     = 8,
  localparam int ADDR_W     = $clog2(ARRAY_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [3:0]         cfg_wdata,
  output logic [2:0]         cfg_mode,
  output logic               cfg_wrap,
  output logic               cfg_err,
  input  logic               start,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic               advance,
  input  logic               stop,
  output logic [ADDR_W-1:0]  addr,
  output logic [COUNT_W-1:0] count,
  output logic               busy,
  output logic               done
);

  logic [2:0]         burst_mode_q;
  logic               burst_wrap_q;
  logic [ADDR_W-1:0]  addr_nxt;
  logic [COUNT_W-1:0] cnt_inc;
  logic [COUNT_W-1:0] grp_words;
  logic               last_word;

  burst_cfg_reg u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .mode_q (cfg_mode),
    .wrap_q (cfg_wrap),
    .err_q  (cfg_err)
  );

  burst_next_addr #(.ADDR_W(ADDR_W)) u_next (
    .cur     (addr),
    .mode    (burst_mode_q),
    .wrap_en (burst_wrap_q),
    .nxt     (addr_nxt)
  );

  always_comb begin
    cnt_inc   = count + 1'b1;
    grp_words = COUNT_W'(1) << group_log2(burst_mode_q);
    last_word = (burst_mode_q != MODE_CONT) && (cnt_inc == grp_words);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr         <= '0;
      count        <= '0;
      busy         <= 1'b0;
      done         <= 1'b0;
      burst_mode_q <= MODE_CONT;
      burst_wrap_q <= 1'b1;
    end else if (start) begin
      addr         <= start_addr;
      count        <= COUNT_W'(1);
      busy         <= 1'b1;
      done         <= 1'b0;
      burst_mode_q <= cfg_mode;
      burst_wrap_q <= cfg_wrap;
    end else if (busy) begin
      if (advance) begin
        addr  <= addr_nxt;
        count <= cnt_inc;
        if (last_word) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
      if (stop) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W  = 24,
  parameter int COUNT_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_err,
  input logic               start,
  input logic [ADDR_W-1:0]  start_addr,
  input logic               advance,
  input logic               stop,
  input logic [ADDR_W-1:0]  addr,
  input logic [COUNT_W-1:0] count,
  input logic               busy,
  input logic               done,
  input logic [2:0]         burst_mode_q,
  input logic               burst_wrap_q
);

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

  assert_start_load_R4: assert property (@(posedge clk) disable iff (rst)
    start |=> (addr == $past(start_addr)) && (count == COUNT_W'(1)) && busy && !done);

  assert_cont_step_R5: assert property (@(posedge clk) disable iff (rst)
    busy && !start && advance && (burst_mode_q == 3'b000)
    |=> addr == ADDR_W'($past(addr) + 1'b1));

  assert_wrap_upper_R6: assert property (@(posedge clk) disable iff (rst)
    busy && !start && advance && burst_wrap_q && (burst_mode_q != 3'b000)
    |=> addr[ADDR_W-1:5] == $past(addr[ADDR_W-1:5]));

  assert_done_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  assert_stop_ends_R9: assert property (@(posedge clk) disable iff (rst)
    busy && stop && !start |=> done && !busy);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !busy && !start |=> $stable(addr) && $stable(count) && $stable(done));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_err      (cfg_err),
  .start        (start),
  .start_addr   (start_addr),
  .advance      (advance),
  .stop         (stop),
  .addr         (addr),
  .count        (count),
  .busy         (busy),
  .done         (done),
  .burst_mode_q (burst_mode_q),
  .burst_wrap_q (burst_wrap_q)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_wdata = '0;
  logic [2:0]    cfg_mode;
  logic          cfg_wrap, cfg_err;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          advance = 1'b0;
  logic          stop = 1'b0;
  logic [AW-1:0] addr;
  logic [CW-1:0] count;
  logic          busy, done;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq i_burst_addr_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_mode(cfg_mode), .cfg_wrap(cfg_wrap), .cfg_err(cfg_err),
    .start(start), .start_addr(start_addr), .advance(advance), .stop(stop),
    .addr(addr), .count(count), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc(); cyc(); rst = 1'b0;
  endtask

  task automatic write_cfg(input logic [3:0] v);
    cfg_we = 1'b1; cfg_wdata = v; cyc(); cfg_we = 1'b0;
  endtask

  task automatic begin_burst(input logic [AW-1:0] a);
    start = 1'b1; start_addr = a; cyc(); start = 1'b0;
  endtask

  task automatic pulse(input bit adv, input bit stp);
    advance = adv; stop = stp; cyc(); advance = 1'b0; stop = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    do_reset();
    chk("R1 addr", 32'(addr), 0);
    chk("R1 count", 32'(count), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 mode", 32'(cfg_mode), 0);
    chk("R1 wrap", 32'(cfg_wrap), 1);
    chk("R1 err", 32'(cfg_err), 0);
  endtask

  task automatic t_cfg();
    write_cfg(4'b1010);
    chk("R2 mode g8", 32'(cfg_mode), 3'b010);
    chk("R2 wrap on", 32'(cfg_wrap), 1);
    write_cfg(4'b0100);
    chk("R2 mode g32", 32'(cfg_mode), 3'b100);
    chk("R2 wrap off", 32'(cfg_wrap), 0);
    chk("R2 no err", 32'(cfg_err), 0);
    write_cfg(4'b1101);
    chk("R3 reserved to cont", 32'(cfg_mode), 0);
    chk("R3 err set", 32'(cfg_err), 1);
    write_cfg(4'b0011);
    chk("R3 legal after", 32'(cfg_mode), 3'b011);
    chk("R3 err sticky", 32'(cfg_err), 1);
    do_reset();
    chk("R3 err cleared by reset", 32'(cfg_err), 0);
  endtask

  task automatic t_wrap8();
    logic [AW-1:0] s = 24'h000105;
    write_cfg(4'b1010);
    begin_burst(s);
    chk("R4 start addr", 32'(addr), 32'(s));
    chk("R4 start count", 32'(count), 1);
    chk("R4 start busy", 32'(busy), 1);
    for (int i = 1; i < 8; i++) begin
      pulse(1'b1, 1'b0);
      chk("R6 wrap8 addr", 32'(addr), 32'((s & ~24'h7) | ((s + 24'(i)) & 24'h7)));
      chk("R8 count", 32'(count), i + 1);
      chk("R8 done", 32'(done), (i == 7) ? 1 : 0);
    end
    chk("R8 busy low", 32'(busy), 0);
    pulse(1'b1, 1'b0);
    chk("R10 addr held", 32'(addr), 32'h000104);
    chk("R10 count held", 32'(count), 8);
    chk("R10 done held", 32'(done), 1);
  endtask

  task automatic t_nowrap();
    logic [AW-1:0] s = 24'h00000E;
    write_cfg(4'b0011);
    begin_burst(s);
    for (int i = 1; i < 16; i++) begin
      pulse(1'b1, 1'b0);
      chk("R7 linear addr", 32'(addr), 32'(s) + i);
      chk("R8 done g16", 32'(done), (i == 15) ? 1 : 0);
    end
    write_cfg(4'b0100);
    begin_burst(24'hFFFFFE);
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    chk("R7 top rollover", 32'(addr), 0);
    chk("R7 busy", 32'(busy), 1);
  endtask

  task automatic t_wrap32_top();
    write_cfg(4'b1100);
    begin_burst(24'hFFFFFD);
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    chk("R6 wrap32 at top", 32'(addr), 32'hFFFFE0);
  endtask

  task automatic t_cont();
    write_cfg(4'b1000);
    begin_burst(24'hFFFFFE);
    for (int i = 1; i <= 40; i++) begin
      pulse(1'b1, 1'b0);
      chk("R5 cont addr", 32'(addr), (32'hFFFFFE + i) & 32'hFFFFFF);
      chk("R5 no done", 32'(done), 0);
    end
    pulse(1'b0, 1'b1);
    chk("R9 stop done", 32'(done), 1);
    chk("R9 stop busy", 32'(busy), 0);
    chk("R9 stop holds addr", 32'(addr), 32'h000026);
    begin_burst(24'h000200);
    pulse(1'b1, 1'b1);
    chk("R9 adv+stop addr", 32'(addr), 32'h000201);
    chk("R9 adv+stop count", 32'(count), 2);
    chk("R9 adv+stop done", 32'(done), 1);
    pulse(1'b1, 1'b1);
    chk("R10 idle addr", 32'(addr), 32'h000201);
    chk("R10 idle count", 32'(count), 2);
  endtask

  task automatic t_collide();
    write_cfg(4'b1010);
    cfg_we = 1'b1; cfg_wdata = 4'b1000;
    start = 1'b1; start_addr = 24'h000007;
    cyc();
    cfg_we = 1'b0; start = 1'b0;
    chk("R4 collide start addr", 32'(addr), 7);
    chk("R2 collide cfg stored", 32'(cfg_mode), 0);
    pulse(1'b1, 1'b0);
    chk("R4 old cfg used", 32'(addr), 0);
    pulse(1'b1, 1'b0);
    begin_burst(24'h000300);
    chk("R4 restart addr", 32'(addr), 32'h000300);
    chk("R4 restart count", 32'(count), 1);
    advance = 1'b1; stop = 1'b1; start = 1'b1; start_addr = 24'h000400;
    cyc();
    advance = 1'b0; stop = 1'b0; start = 1'b0;
    chk("R4 start priority addr", 32'(addr), 32'h000400);
    chk("R4 start priority busy", 32'(busy), 1);
    chk("R4 start priority done", 32'(done), 0);
  endtask

  initial begin
    t_reset();
    t_cfg();
    t_wrap8();
    t_nowrap();
    t_wrap32_top();
    t_cont();
    t_collide();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule